// File: doc/BRIEF.md
# Dual-Plane Egress Buffer and Plane Selector

This block sits on the egress side of a redundant attachment to a switch that has two planes, X and Y. Each plane delivers cells from its own extraction stage on its own clock into a private asynchronous FIFO. The processing-element (PE) clock domain reads from these FIFOs. A selector forwards the cells of whichever plane the switch reports as in service, one 32-bit word at a time, with a flag on the first word of each 20-word cell. Each FIFO holds six cells. This depth covers a switch that needs up to three cells of time to react to a change in the send grant, in either direction.

Each plane reports an almost-full condition against a programmable level, and the send grant toward the switch is the inverse of that condition. It also reports a not-empty condition against a second programmable level. Words are written only into the FIFO of a plane whose in-service input is high, after that input has been resynchronised to the plane's clock. Words offered to a plane that is out of service are taken and dropped. The selector resynchronises both in-service inputs to the PE clock. It changes plane only between cells, so a cell already under way always finishes from the plane it began on. Cells left behind in the old plane's FIFO are not read while that plane is deselected. A changeover may therefore lose or repeat cells, and that is accepted.

All write-side streams and the output stream use valid/ready. A word moves on a clock edge where both are high. While valid is high and ready is low, the sender holds the word unchanged. The writer may drop valid at any time. The output keeps its word, first-word flag and plane indication until the word is taken.

Top module: `dual_plane_egress`

## Requirements
- R1: After reset, out_valid is low, both send grants and both input readies are high, and both almost-full and not-empty indications are low.
- R2: Cells written on the in-service plane leave on the output in write order, with out_data and out_sop equal to the written word and flag, and out_plane shows the source (0 = X, 1 = Y).
- R3: While a plane's in-service input is low, that plane's in_ready stays high, and the words it accepts never reach the output and never raise its not-empty indication.
- R4: Each plane FIFO holds exactly 120 words (six 20-word cells). With no reads, the 121st offered word finds in_ready low.
- R5: A plane's almost-full output is high exactly when its write-side fill is at or above afull_lvl. Its send grant is the inverse of almost-full, and it returns once reads bring the fill back below the level.
- R6: A plane's not-empty output is high when its read-side fill is at least nempty_lvl, and it stays low for a smaller non-zero fill.
- R7: out_plane changes only when a whole number of 20-word cells has been taken since reset. A cell that has started on one plane completes from that plane after the in-service inputs move to the other.
- R8: When both or neither in-service inputs are high, the selected plane is held. The deselected FIFO is not read, so its not-empty stays high while it holds words.
- R9: While out_valid is high and out_ready is low, out_valid stays high on the next cycle, and out_data, out_sop and out_plane do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pe | input | 1 | PE clock: read side and selector |
| clk_x | input | 1 | Plane X write clock |
| clk_y | input | 1 | Plane Y write clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| x_in_service | input | 1 | Switch marks plane X in service (asynchronous) |
| y_in_service | input | 1 | Switch marks plane Y in service (asynchronous) |
| afull_lvl | input | 8 | Almost-full level in words, both planes |
| nempty_lvl | input | 8 | Not-empty level in words, both planes |
| x_in_valid | input | 1 | Plane X word valid |
| x_in_ready | output | 1 | Plane X can take a word |
| x_in_data | input | 32 | Plane X word |
| x_in_sop | input | 1 | Plane X first word of a cell |
| x_send_grant | output | 1 | Send grant toward plane X (clk_x domain) |
| x_afull | output | 1 | Plane X almost full (clk_x domain) |
| x_nempty | output | 1 | Plane X not empty by level (clk_pe domain) |
| y_in_valid | input | 1 | Plane Y word valid |
| y_in_ready | output | 1 | Plane Y can take a word |
| y_in_data | input | 32 | Plane Y word |
| y_in_sop | input | 1 | Plane Y first word of a cell |
| y_send_grant | output | 1 | Send grant toward plane Y (clk_y domain) |
| y_afull | output | 1 | Plane Y almost full (clk_y domain) |
| y_nempty | output | 1 | Plane Y not empty by level (clk_pe domain) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Output word starts a cell |
| out_plane | output | 1 | Plane of the output word (0 = X, 1 = Y) |

## Verification
The assertions check three things on every cycle. The output word is held while it is stalled. The plane indication moves only after a whole number of cells has been taken, counted independently of the selector. A plane with no room never shows a raised send grant when the almost-full level is within capacity. The bench scenarios cover the rest: exact capacity, the threshold crossings in both directions, discarding of words on an out-of-service plane, and the order of words through a mid-cell changeover. They also show that a deselected FIFO keeps its contents when both or neither plane is in service.

// File: rtl/egr_pkg.sv
package egr_pkg;
  typedef enum logic {PLANE_X = 1'b0, PLANE_Y = 1'b1} plane_e;
endpackage

// File: rtl/egr_sync.sv
module egr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/egr_plane_fifo.sv
module egr_plane_fifo #(
  parameter int  DATA_W = 32,
  parameter int  CAP    = 120,
  localparam int AW     = $clog2(CAP),
  localparam int PW     = AW + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  // write side
  input  logic              wr_allow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic [PW-1:0]     afull_lvl,
  output logic              afull,
  output logic              grant,
  // read side
  input  logic              rd_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  input  logic [PW-1:0]     nempty_lvl,
  output logic              nempty
);
  localparam int SLOTS = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W:0] mem [SLOTS];

  // ---------------- write domain ----------------
  logic [PW-1:0] wbin, wgray, rgray_w, fill_w, wbin_nx;
  logic          full, push;

  egr_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  assign fill_w   = wbin - from_gray(rgray_w);
  assign full     = fill_w >= PW'(CAP);
  assign push     = in_valid && wr_allow && !full;
  assign in_ready = !wr_allow || !full;
  assign wbin_nx  = wbin + PW'(1);
  assign afull    = fill_w >= afull_lvl;
  assign grant    = !afull;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= {in_sop, in_data};
  end

  // ---------------- read domain ----------------
  logic [PW-1:0] rbin, rgray, wgray_r, fill_r, rbin_nx;
  logic          take;

  egr_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign fill_r   = from_gray(wgray_r) - rbin;
  assign rd_valid = fill_r != '0;
  assign take     = rd_pop && rd_valid;
  assign rbin_nx  = rbin + PW'(1);
  assign {rd_sop, rd_data} = mem[rbin[AW-1:0]];
  assign nempty   = rd_valid && (fill_r >= nempty_lvl);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (take) begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end
  end
endmodule

// File: rtl/egr_plane_select.sv
module egr_plane_select
  import egr_pkg::*;
#(
  parameter int  DATA_W     = 32,
  parameter int  CELL_WORDS = 20,
  localparam int CW         = $clog2(CELL_WORDS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             srv,
  input  logic [1:0]             src_valid,
  input  logic [1:0][DATA_W-1:0] src_data,
  input  logic [1:0]             src_sop,
  output logic [1:0]             src_pop,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_sop,
  output logic                   out_plane
);
  plane_e        cur, want;
  logic [CW-1:0] cnt;
  logic          offered_q, switching, take, sel_i;

  always_comb begin
    want = cur;
    if (srv[0] ^ srv[1]) want = srv[1] ? PLANE_Y : PLANE_X;
  end

  assign sel_i     = cur;
  assign switching = (cnt == '0) && !offered_q && (want != cur);
  assign out_valid = src_valid[sel_i] && !switching;
  assign out_data  = src_data[sel_i];
  assign out_sop   = src_sop[sel_i];
  assign out_plane = sel_i;
  assign take      = out_valid && out_ready;
  assign src_pop   = take ? (2'b01 << sel_i) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= PLANE_X;
      cnt       <= '0;
      offered_q <= 1'b0;
    end else begin
      offered_q <= out_valid && !out_ready;
      if (switching) cur <= want;
      if (take) cnt <= (cnt == CW'(CELL_WORDS - 1)) ? '0 : cnt + CW'(1);
    end
  end
endmodule

// File: rtl/dual_plane_egress.sv
module dual_plane_egress #(
  parameter int  DATA_W     = 32,
  parameter int  CELL_WORDS = 20,
  parameter int  CELLS      = 6,
  localparam int CAP        = CELL_WORDS * CELLS,
  localparam int PW         = $clog2(CAP) + 1
) (
  input  logic              clk_pe,
  input  logic              clk_x,
  input  logic              clk_y,
  input  logic              rst_n,
  input  logic              x_in_service,
  input  logic              y_in_service,
  input  logic [PW-1:0]     afull_lvl,
  input  logic [PW-1:0]     nempty_lvl,
  input  logic              x_in_valid,
  output logic              x_in_ready,
  input  logic [DATA_W-1:0] x_in_data,
  input  logic              x_in_sop,
  output logic              x_send_grant,
  output logic              x_afull,
  output logic              x_nempty,
  input  logic              y_in_valid,
  output logic              y_in_ready,
  input  logic [DATA_W-1:0] y_in_data,
  input  logic              y_in_sop,
  output logic              y_send_grant,
  output logic              y_afull,
  output logic              y_nempty,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_plane
);
  logic [1:0]             wclk, srv_raw, srv_w, srv_pe;
  logic [1:0]             in_valid, in_ready, in_sop, grant, afull, nempty;
  logic [1:0][DATA_W-1:0] in_data, rd_data;
  logic [1:0]             rd_valid, rd_sop, rd_pop;

  assign wclk     = {clk_y, clk_x};
  assign srv_raw  = {y_in_service, x_in_service};
  assign in_valid = {y_in_valid, x_in_valid};
  assign in_sop   = {y_in_sop, x_in_sop};
  assign in_data  = {y_in_data, x_in_data};

  assign x_in_ready   = in_ready[0];
  assign y_in_ready   = in_ready[1];
  assign x_send_grant = grant[0];
  assign y_send_grant = grant[1];
  assign x_afull      = afull[0];
  assign y_afull      = afull[1];
  assign x_nempty     = nempty[0];
  assign y_nempty     = nempty[1];

  egr_sync #(.W(2)) u_srv_pe (.clk(clk_pe), .rst_n(rst_n), .d(srv_raw), .q(srv_pe));

  for (genvar p = 0; p < 2; p++) begin : g_plane
    egr_sync #(.W(1)) u_srv_w (
      .clk(wclk[p]), .rst_n(rst_n), .d(srv_raw[p]), .q(srv_w[p])
    );

    egr_plane_fifo #(.DATA_W(DATA_W), .CAP(CAP)) u_fifo (
      .wclk      (wclk[p]),
      .rclk      (clk_pe),
      .rst_n     (rst_n),
      .wr_allow  (srv_w[p]),
      .in_valid  (in_valid[p]),
      .in_ready  (in_ready[p]),
      .in_data   (in_data[p]),
      .in_sop    (in_sop[p]),
      .afull_lvl (afull_lvl),
      .afull     (afull[p]),
      .grant     (grant[p]),
      .rd_pop    (rd_pop[p]),
      .rd_valid  (rd_valid[p]),
      .rd_data   (rd_data[p]),
      .rd_sop    (rd_sop[p]),
      .nempty_lvl(nempty_lvl),
      .nempty    (nempty[p])
    );
  end

  egr_plane_select #(.DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS)) u_sel (
    .clk      (clk_pe),
    .rst_n    (rst_n),
    .srv      (srv_pe),
    .src_valid(rd_valid),
    .src_data (rd_data),
    .src_sop  (rd_sop),
    .src_pop  (rd_pop),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_plane(out_plane)
  );
endmodule

// File: rtl/egress_checks.sv
module egress_checks #(
  parameter int DATA_W     = 32,
  parameter int CELL_WORDS = 20,
  parameter int CAP        = 120,
  parameter int PW         = 8
) (
  input logic              clk_pe,
  input logic              clk_x,
  input logic              clk_y,
  input logic              rst_n,
  input logic [PW-1:0]     afull_lvl,
  input logic              x_in_ready,
  input logic              x_send_grant,
  input logic              y_in_ready,
  input logic              y_send_grant,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_plane
);
  localparam int CW = $clog2(CELL_WORDS);
  logic [CW-1:0] ck_cnt;

  // independent count of words taken, modulo one cell
  always_ff @(posedge clk_pe or negedge rst_n) begin
    if (!rst_n) ck_cnt <= '0;
    else if (out_valid && out_ready)
      ck_cnt <= (ck_cnt == CW'(CELL_WORDS - 1)) ? '0 : ck_cnt + CW'(1);
  end

  p_hold_stalled_r9: assert property (@(posedge clk_pe) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_plane)));

  p_switch_on_boundary_r7: assert property (@(posedge clk_pe) disable iff (!rst_n)
    (out_plane != $past(out_plane)) |-> (ck_cnt == '0));

  p_full_drops_grant_x_r5: assert property (@(posedge clk_x) disable iff (!rst_n)
    (!x_in_ready && (afull_lvl <= PW'(CAP))) |-> !x_send_grant);

  p_full_drops_grant_y_r5: assert property (@(posedge clk_y) disable iff (!rst_n)
    (!y_in_ready && (afull_lvl <= PW'(CAP))) |-> !y_send_grant);
endmodule

bind dual_plane_egress egress_checks #(
  .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .CAP(CAP), .PW(PW)
) u_chk (
  .clk_pe      (clk_pe),
  .clk_x       (clk_x),
  .clk_y       (clk_y),
  .rst_n       (rst_n),
  .afull_lvl   (afull_lvl),
  .x_in_ready  (x_in_ready),
  .x_send_grant(x_send_grant),
  .y_in_ready  (y_in_ready),
  .y_send_grant(y_send_grant),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_sop     (out_sop),
  .out_plane   (out_plane)
);

// File: tb/sim_dual_plane_egress.sv
`timescale 1ns/1ps
module sim_dual_plane_egress;
  localparam int CW  = 20;
  localparam int CAP = 120;

  logic clk_pe = 0, clk_x = 0, clk_y = 0, rst_n = 0;
  logic x_in_service = 0, y_in_service = 0;
  logic [7:0] afull_lvl = 8'd100, nempty_lvl = 8'd1;
  logic x_in_valid = 0, x_in_sop = 0, y_in_valid = 0, y_in_sop = 0;
  logic [31:0] x_in_data = '0, y_in_data = '0;
  logic x_in_ready, x_send_grant, x_afull, x_nempty;
  logic y_in_ready, y_send_grant, y_afull, y_nempty;
  logic out_valid, out_ready = 0, out_sop, out_plane;
  logic [31:0] out_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_pe = ~clk_pe;
  always #3.5 clk_x  = ~clk_x;
  always #4.5 clk_y  = ~clk_y;

  dual_plane_egress u0 (.*);

  function automatic logic [31:0] wd(input logic [7:0] tag, input bit pl, input int idx);
    return {tag, 7'd0, pl, 8'hA5, 8'(idx)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_pe(input int n);
    repeat (n) @(negedge clk_pe);
  endtask

  task automatic do_reset(input bit sx, input bit sy);
    rst_n = 0;
    x_in_valid = 0; y_in_valid = 0; out_ready = 0;
    x_in_service = sx; y_in_service = sy;
    afull_lvl = 8'd100; nempty_lvl = 8'd1;
    wait_pe(4);
    rst_n = 1;
    wait_pe(12);
  endtask

  task automatic set_srv(input bit sx, input bit sy);
    x_in_service = sx; y_in_service = sy;
    wait_pe(12);
  endtask

  task automatic offer(input bit pl, input logic [31:0] d, input bit s, output bit acc);
    if (!pl) begin
      @(negedge clk_x);
      x_in_valid = 1; x_in_data = d; x_in_sop = s; acc = x_in_ready;
      @(posedge clk_x); #1 x_in_valid = 0;
    end else begin
      @(negedge clk_y);
      y_in_valid = 1; y_in_data = d; y_in_sop = s; acc = y_in_ready;
      @(posedge clk_y); #1 y_in_valid = 0;
    end
  endtask

  task automatic push_words(input bit pl, input logic [7:0] tag, input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      bit acc = 0;
      int tries = 0;
      while (!acc && tries < 2000) begin
        offer(pl, wd(tag, pl, i % CW), (i % CW) == 0, acc);
        tries++;
      end
    end
  endtask

  task automatic pop(output logic [31:0] d, output bit s, output bit p, output bit got);
    @(negedge clk_pe);
    out_ready = 1;
    got = out_valid; d = out_data; s = out_sop; p = out_plane;
    @(posedge clk_pe); #1 out_ready = 0;
  endtask

  task automatic expect_words(input string req, input bit pl, input logic [7:0] tag,
                              input int first, input int n);
    for (int i = first; i < first + n; i++) begin
      logic [31:0] d;
      bit s, p, got;
      int tries = 0;
      got = 0;
      while (!got && tries < 400) begin
        pop(d, s, p, got);
        tries++;
      end
      chk(got, req, "word arrives", 64'(got), 64'd1);
      if (got) begin
        chk(d == wd(tag, pl, i % CW), req, "out_data", 64'(d), 64'(wd(tag, pl, i % CW)));
        chk(s == ((i % CW) == 0), req, "out_sop", 64'(s), 64'((i % CW) == 0));
        chk(p == pl, req, "out_plane", 64'(p), 64'(pl));
      end
    end
  endtask

  // R1
  task automatic t_reset;
    do_reset(1, 0);
    chk(out_valid == 0, "R1", "out_valid", 64'(out_valid), 64'd0);
    chk(x_send_grant && y_send_grant, "R1", "grants", 64'({x_send_grant, y_send_grant}), 64'd3);
    chk(x_in_ready && y_in_ready, "R1", "readies", 64'({x_in_ready, y_in_ready}), 64'd3);
    chk(!x_afull && !y_afull, "R1", "afull", 64'({x_afull, y_afull}), 64'd0);
    chk(!x_nempty && !y_nempty, "R1", "nempty", 64'({x_nempty, y_nempty}), 64'd0);
  endtask

  // R2
  task automatic t_forward;
    do_reset(1, 0);
    push_words(0, 8'h11, 0, CW);
    push_words(0, 8'h12, 0, CW);
    expect_words("R2", 0, 8'h11, 0, CW);
    expect_words("R2", 0, 8'h12, 0, CW);
    wait_pe(10);
    chk(out_valid == 0, "R2", "idle after drain", 64'(out_valid), 64'd0);
    do_reset(0, 1);
    push_words(1, 8'h21, 0, CW);
    expect_words("R2", 1, 8'h21, 0, CW);
  endtask

  // R3
  task automatic t_discard;
    int nacc = 0;
    do_reset(1, 0);
    for (int i = 0; i < 10; i++) begin
      bit acc;
      offer(1, wd(8'h31, 1, i), i == 0, acc);
      if (acc) nacc++;
    end
    chk(nacc == 10, "R3", "y ready while out of service", 64'(nacc), 64'd10);
    wait_pe(20);
    chk(y_nempty == 0, "R3", "y_nempty", 64'(y_nempty), 64'd0);
    chk(out_valid == 0, "R3", "nothing forwarded", 64'(out_valid), 64'd0);
  endtask

  // R4
  task automatic t_capacity;
    int nacc = 0;
    bit acc = 1;
    do_reset(1, 0);
    afull_lvl = 8'(CAP);
    for (int i = 0; i < CAP + 10 && acc; i++) begin
      offer(0, wd(8'h41, 0, nacc % CW), (nacc % CW) == 0, acc);
      if (acc) nacc++;
    end
    chk(nacc == CAP, "R4", "words held", 64'(nacc), 64'(CAP));
    chk(x_in_ready == 0, "R4", "ready when full", 64'(x_in_ready), 64'd0);
    chk(x_send_grant == 0, "R4", "grant when full", 64'(x_send_grant), 64'd0);
    expect_words("R4", 0, 8'h41, 0, CAP);
    repeat (10) @(negedge clk_x);
    chk(x_in_ready == 1, "R4", "ready after drain", 64'(x_in_ready), 64'd1);
  endtask

  // R5
  task automatic t_afull;
    do_reset(1, 0);
    afull_lvl = 8'd40;
    push_words(0, 8'h51, 0, 39);
    chk(x_afull == 0, "R5", "afull below level", 64'(x_afull), 64'd0);
    chk(x_send_grant == 1, "R5", "grant below level", 64'(x_send_grant), 64'd1);
    push_words(0, 8'h51, 39, 1);
    chk(x_afull == 1, "R5", "afull at level", 64'(x_afull), 64'd1);
    chk(x_send_grant == 0, "R5", "grant at level", 64'(x_send_grant), 64'd0);
    expect_words("R5", 0, 8'h51, 0, 10);
    repeat (10) @(negedge clk_x);
    chk(x_afull == 0, "R5", "afull after reads", 64'(x_afull), 64'd0);
    chk(x_send_grant == 1, "R5", "grant after reads", 64'(x_send_grant), 64'd1);
  endtask

  // R6
  task automatic t_nempty;
    do_reset(1, 0);
    nempty_lvl = 8'd20;
    push_words(0, 8'h61, 0, 19);
    wait_pe(12);
    chk(x_nempty == 0, "R6", "nempty below level", 64'(x_nempty), 64'd0);
    chk(out_valid == 1, "R6", "data present", 64'(out_valid), 64'd1);
    push_words(0, 8'h61, 19, 1);
    wait_pe(12);
    chk(x_nempty == 1, "R6", "nempty at level", 64'(x_nempty), 64'd1);
  endtask

  // R7
  task automatic t_boundary;
    do_reset(1, 0);
    push_words(0, 8'h71, 0, CW);
    push_words(0, 8'h72, 0, CW);
    expect_words("R7", 0, 8'h71, 0, 5);
    set_srv(0, 1);
    push_words(1, 8'h73, 0, CW);
    expect_words("R7", 0, 8'h71, 5, CW - 5);
    expect_words("R7", 1, 8'h73, 0, CW);
  endtask

  // R8
  task automatic t_hold;
    do_reset(0, 1);
    set_srv(1, 1);
    push_words(0, 8'h81, 0, CW);
    push_words(1, 8'h82, 0, CW);
    expect_words("R8", 1, 8'h82, 0, CW);
    wait_pe(30);
    chk(out_valid == 0, "R8", "x halted while both", 64'(out_valid), 64'd0);
    chk(x_nempty == 1, "R8", "x keeps contents", 64'(x_nempty), 64'd1);
    set_srv(0, 0);
    wait_pe(10);
    chk(out_plane == 1, "R8", "plane held with neither", 64'(out_plane), 64'd1);
    chk(out_valid == 0, "R8", "x still halted", 64'(out_valid), 64'd0);
  endtask

  // R9
  task automatic t_stall;
    logic [31:0] d0;
    bit s0;
    int tries = 0;
    do_reset(1, 0);
    push_words(0, 8'h91, 0, CW);
    while (!out_valid && tries < 200) begin wait_pe(1); tries++; end
    d0 = out_data; s0 = out_sop;
    for (int i = 0; i < 5; i++) begin
      wait_pe(1);
      chk(out_valid && out_data == d0 && out_sop == s0, "R9", "held word",
          64'(out_data), 64'(d0));
    end
    expect_words("R9", 0, 8'h91, 0, CW);
  endtask

  initial begin
    #900_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_forward();
    t_discard();
    t_capacity();
    t_afull();
    t_nempty();
    t_boundary();
    t_hold();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule